// File: doc/BRIEF.md
# TDM Channel Strobe Generator

This block produces per-channel timing signals for one serial transmit stream carrying T1 or E1 frames. It runs on the stream's bit clock, which may be the line clock or the system clock used behind an elastic store. It keeps a running bit position within the frame, and a frame-sync pulse can realign that position at any time. From the position it derives the current channel and bit, and it drives two outputs.

The first output is a per-channel level taken from a programmable block mask. It is used to gate the clock of a serial HDLC controller in fractional links, or to mark channels for drop-and-insert. The second output, the channel clock, works in one of two modes. In gapped mode it passes the bit clock only during enabled channels, which yields an N x 64 kHz clock. In T1 frames the framing bit has a separate enable. In pulse mode it is high for the whole last bit (LSB) of every channel.

Both masks are loaded one bit at a time through a simple write port. Channel data is sent MSB first, so the LSB is the eighth bit of each channel.

Top module: `chs_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `blk_out` and `chclk_out` are both 0, and both masks clear to 0.
- R2: A bit period begins at each rising edge of `clk`. If `fsync` is 1 at that edge, the new bit is frame position 0. Otherwise the position advances by one and wraps to 0 after position 192 (T1, `e1_mode`=0) or 255 (E1, `e1_mode`=1). A position above the T1 limit also wraps to 0 when the mode switches to T1.
- R3: In T1 mode, position 0 is the framing bit, and channel c (0..23) occupies positions 1+8c to 8+8c, MSB first.
- R4: In E1 mode, channel c (0..31) occupies positions 8c to 8c+7, MSB first.
- R5: During a channel bit, `blk_out` equals the block-mask bit of that channel. During the T1 framing bit it is 0. It changes only at rising edges of `clk`.
- R6: In gapped mode (`gap_mode`=1), `chclk_out` follows `clk` during bits of channels whose clock-enable bit is 1, and is 0 throughout all other channel bits.
- R7: In T1 gapped mode, `chclk_out` follows `clk` during the framing bit if and only if `fbit_en` is 1.
- R8: In pulse mode (`gap_mode`=0), `chclk_out` is 1 for the entire LSB bit of each channel and 0 during every other bit, including the T1 framing bit.
- R9: When `wr_en` is 1 at a rising edge, `wr_dat` is stored for channel `wr_ch`. The target is the block mask when `wr_sel`=0 and the clock-enable mask when `wr_sel`=1. The stored bit is used from the next bit period on.
- R10: In T1 mode, mask entries 24..31 have no effect on either output.
- R11: `gap_mode`, `fbit_en` and `e1_mode` take effect at the bit that begins at the rising edge where they are sampled, and never part-way through a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| e1_mode | input | 1 | 1 = E1 frame (256 bits), 0 = T1 frame (193 bits) |
| fsync | input | 1 | Frame-sync pulse; the next bit is position 0 |
| gap_mode | input | 1 | 1 = gapped clock, 0 = LSB pulse |
| fbit_en | input | 1 | Includes the T1 framing bit in the gapped clock |
| wr_en | input | 1 | Mask write strobe |
| wr_sel | input | 1 | 0 = block mask, 1 = clock-enable mask |
| wr_ch | input | 5 | Channel index of the write |
| wr_dat | input | 1 | Mask bit value |
| blk_out | output | 1 | Per-channel block level |
| chclk_out | output | 1 | Gapped clock or channel LSB pulse |

## Verification
The hardest conditions to reach are the ones where a control changes while a frame is running. These include a frame-sync pulse in the middle of a frame, a switch from E1 to T1 while the position is already past the T1 limit, a switch between gapped and pulse mode every few bits, and a mask written just before the channel that uses it. The stimulus is a bit-by-bit driver that holds its own model of position and masks. It applies these changes at chosen positions and queues the expected block level, the channel-clock level in the high phase and the level in the low phase for every bit. Each bit is then compared in both clock phases. Clearing the T1 channels while only entries 24..31 stay set shows that those entries have no effect in T1 mode.

// File: rtl/chs_pkg.sv
package chs_pkg;

   // Largest number of channels any frame format may carry.
   parameter int unsigned CHS_MAX_CH = 32;
   localparam int unsigned CHS_CH_W = $clog2(CHS_MAX_CH);

   // Selects which mask a write lands in.
   typedef enum logic {
      MASK_BLK = 1'b0,
      MASK_CLK = 1'b1
   } mask_sel_e;

   // Decoded view of one bit position.
   typedef struct packed {
      logic                fbit;
      logic                lsb;
      logic [CHS_CH_W-1:0] ch;
   } slot_t;

endpackage

// File: rtl/chs_pos_counter.sv
module chs_pos_counter #(
   parameter int unsigned T1_CH   = 24,
   parameter int unsigned E1_CH   = 32,
   parameter int unsigned CH_BITS = 8,
   parameter int unsigned POS_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             e1_mode,
   input  logic             fsync,
   output logic [POS_W-1:0] pos_q,
   output logic [POS_W-1:0] pos_nxt,
   output logic             e1_q
);

   localparam int unsigned T1_LAST = T1_CH * CH_BITS;
   localparam int unsigned E1_LAST = E1_CH * CH_BITS - 1;

   if (E1_LAST >= (1 << POS_W)) begin : g_bad_pos_w
      $error("chs_pos_counter: POS_W too narrow for the E1 frame");
   end

   logic [POS_W-1:0] last_pos;

   always_comb begin
      last_pos = e1_mode ? POS_W'(E1_LAST) : POS_W'(T1_LAST);
      if (fsync || (pos_q >= last_pos)) begin
         pos_nxt = '0;
      end else begin
         pos_nxt = pos_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         e1_q  <= 1'b0;
      end else begin
         pos_q <= pos_nxt;
         e1_q  <= e1_mode;
      end
   end

   // R2
   fsync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (pos_q == '0));

   // R2
   t1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!e1_q && $stable(e1_q)) |-> (pos_q <= POS_W'(T1_LAST)));

endmodule

// File: rtl/chs_slot_decode.sv
module chs_slot_decode #(
   parameter int unsigned CH_BITS = 8,
   parameter int unsigned POS_W   = 8
) (
   input  logic              e1_mode,
   input  logic [POS_W-1:0]  pos,
   output chs_pkg::slot_t    slot
);

   localparam int unsigned BIT_W = $clog2(CH_BITS);
   localparam int unsigned CH_W  = chs_pkg::CHS_CH_W;

   if ((CH_BITS & (CH_BITS - 1)) != 0) begin : g_bad_bits
      $error("chs_slot_decode: CH_BITS must be a power of two");
   end
   if (BIT_W + CH_W > POS_W) begin : g_bad_split
      $error("chs_slot_decode: position too narrow for channel split");
   end

   logic [POS_W-1:0] off;

   always_comb begin
      // T1 channels start one bit after the framing bit.
      off       = e1_mode ? pos : (pos - 1'b1);
      slot.fbit = !e1_mode && (pos == '0);
      slot.ch   = off[BIT_W +: CH_W];
      slot.lsb  = !slot.fbit && (off[BIT_W-1:0] == BIT_W'(CH_BITS - 1));
   end

endmodule

// File: rtl/chs_mask_bank.sv
module chs_mask_bank #(
   parameter int unsigned NCH  = 32,
   parameter int unsigned CH_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_sel,
   input  logic [CH_W-1:0] wr_ch,
   input  logic            wr_dat,
   input  logic [CH_W-1:0] rd_ch,
   output logic            blk_bit,
   output logic            clk_bit
);

   import chs_pkg::*;

   if (NCH > (1 << CH_W)) begin : g_bad_nch
      $error("chs_mask_bank: NCH exceeds channel index range");
   end

   logic [NCH-1:0] blk_m;
   logic [NCH-1:0] clk_m;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic b_q;
      logic e_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_q <= 1'b0;
            e_q <= 1'b0;
         end else if (wr_en && (wr_ch == CH_W'(c))) begin
            if (mask_sel_e'(wr_sel) == MASK_BLK) begin
               b_q <= wr_dat;
            end else begin
               e_q <= wr_dat;
            end
         end
      end
      assign blk_m[c] = b_q;
      assign clk_m[c] = e_q;
   end

   always_comb begin
      if (int'(rd_ch) < int'(NCH)) begin
         blk_bit = blk_m[rd_ch];
         clk_bit = clk_m[rd_ch];
      end else begin
         blk_bit = 1'b0;
         clk_bit = 1'b0;
      end
   end

   // R9
   blk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == MASK_BLK) && (int'(wr_ch) < int'(NCH)))
      |=> (blk_m[$past(wr_ch)] == $past(wr_dat)));

   // R9
   clk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == MASK_CLK) && (int'(wr_ch) < int'(NCH)))
      |=> (clk_m[$past(wr_ch)] == $past(wr_dat)));

endmodule

// File: rtl/chs_out_stage.sv
module chs_out_stage (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           gap_mode,
   input  logic           fbit_en,
   input  logic           e1_mode,
   input  chs_pkg::slot_t slot,
   input  logic           blk_bit,
   input  logic           clk_bit,
   output logic           blk_out,
   output logic           chclk_out
);

   logic blk_q;
   logic lsb_q;
   logic mode_q;
   logic gate_q;

   // Levels for the bit that starts at this edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q  <= 1'b0;
         lsb_q  <= 1'b0;
         mode_q <= 1'b0;
      end else begin
         blk_q  <= slot.fbit ? 1'b0 : blk_bit;
         lsb_q  <= slot.lsb;
         mode_q <= gap_mode;
      end
   end

   // Clock gate enable moves only while clk is low: no runt pulses.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else begin
         gate_q <= slot.fbit ? fbit_en : clk_bit;
      end
   end

   assign blk_out   = blk_q;
   assign chclk_out = mode_q ? (clk & gate_q) : lsb_q;

   // R8
   lsb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lsb_q |=> (!lsb_q || !$stable(e1_mode)));

endmodule

// File: rtl/chs_strobe_gen.sv
module chs_strobe_gen #(
   parameter int unsigned T1_CH   = 24,
   parameter int unsigned E1_CH   = 32,
   parameter int unsigned CH_BITS = 8,
   localparam int unsigned CH_W   = chs_pkg::CHS_CH_W,
   localparam int unsigned POS_W  = $clog2(E1_CH * CH_BITS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            e1_mode,
   input  logic            fsync,
   input  logic            gap_mode,
   input  logic            fbit_en,
   input  logic            wr_en,
   input  logic            wr_sel,
   input  logic [CH_W-1:0] wr_ch,
   input  logic            wr_dat,
   output logic            blk_out,
   output logic            chclk_out
);

   if (E1_CH > chs_pkg::CHS_MAX_CH) begin : g_bad_e1
      $error("chs_strobe_gen: E1_CH exceeds package channel limit");
   end
   if (T1_CH > E1_CH) begin : g_bad_t1
      $error("chs_strobe_gen: T1_CH must not exceed E1_CH");
   end

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_nxt;
   logic             e1_q;
   chs_pkg::slot_t   slot_nxt;
   logic             blk_bit;
   logic             clk_bit;

   chs_pos_counter #(
      .T1_CH   (T1_CH),
      .E1_CH   (E1_CH),
      .CH_BITS (CH_BITS),
      .POS_W   (POS_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .e1_mode (e1_mode),
      .fsync   (fsync),
      .pos_q   (pos_q),
      .pos_nxt (pos_nxt),
      .e1_q    (e1_q)
   );

   chs_slot_decode #(
      .CH_BITS (CH_BITS),
      .POS_W   (POS_W)
   ) u_dec (
      .e1_mode (e1_mode),
      .pos     (pos_nxt),
      .slot    (slot_nxt)
   );

   chs_mask_bank #(
      .NCH  (E1_CH),
      .CH_W (CH_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_ch   (wr_ch),
      .wr_dat  (wr_dat),
      .rd_ch   (slot_nxt.ch),
      .blk_bit (blk_bit),
      .clk_bit (clk_bit)
   );

   chs_out_stage u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .gap_mode  (gap_mode),
      .fbit_en   (fbit_en),
      .e1_mode   (e1_mode),
      .slot      (slot_nxt),
      .blk_bit   (blk_bit),
      .clk_bit   (clk_bit),
      .blk_out   (blk_out),
      .chclk_out (chclk_out)
   );

   // R5
   fbit_blk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!e1_q && (pos_q == '0)) |-> !blk_out);

endmodule

// File: tb/tb_chs_strobe_gen.sv
module tb_chs_strobe_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       e1_mode = 1'b0;
   logic       fsync = 1'b0;
   logic       gap_mode = 1'b0;
   logic       fbit_en = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [4:0] wr_ch = '0;
   logic       wr_dat = 1'b0;
   logic       blk_out;
   logic       chclk_out;

   always #10 clk = ~clk;

   chs_strobe_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .e1_mode   (e1_mode),
      .fsync     (fsync),
      .gap_mode  (gap_mode),
      .fbit_en   (fbit_en),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_ch     (wr_ch),
      .wr_dat    (wr_dat),
      .blk_out   (blk_out),
      .chclk_out (chclk_out)
   );

   typedef struct {
      logic  blk;
      logic  hi;
      logic  lo;
      string tb;
      string tc;
   } exp_t;

   exp_t  expq[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string scen = "R1";

   // Bench model state
   int mpos = 0;
   bit blkm [32];
   bit clkm [32];
   bit m_e1 = 1'b0;
   bit m_gap = 1'b0;
   bit m_fb = 1'b0;

   task automatic chk(string tag, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // Drives one bit period; expected levels queued for the monitor.
   task automatic drive_bit(bit fs, bit we = 1'b0, bit sel = 1'b0,
                            int ch = 0, bit dat = 1'b0);
      int   lastp;
      int   nxt;
      int   off;
      int   c;
      bit   fb;
      bit   lsb;
      bit   gate;
      exp_t e;
      #1;
      fsync = fs; e1_mode = m_e1; gap_mode = m_gap; fbit_en = m_fb;
      wr_en = we; wr_sel = sel; wr_ch = ch[4:0]; wr_dat = dat;
      lastp = m_e1 ? 255 : 192;
      nxt   = (fs || mpos >= lastp) ? 0 : mpos + 1;
      fb    = !m_e1 && (nxt == 0);
      off   = m_e1 ? nxt : nxt - 1;
      c     = fb ? 0 : off / 8;
      lsb   = !fb && ((off % 8) == 7);
      gate  = fb ? m_fb : clkm[c];
      e.blk = fb ? 1'b0 : blkm[c];
      e.hi  = m_gap ? gate : lsb;
      e.lo  = m_gap ? 1'b0 : lsb;
      e.tb  = $sformatf("%s %s R5", scen, m_e1 ? "R4" : "R3");
      e.tc  = $sformatf("%s %s", scen, m_gap ? (fb ? "R7" : "R6") : "R8");
      if (we) begin
         if (sel) clkm[ch] = dat;
         else     blkm[ch] = dat;
      end
      @(posedge clk);
      mpos = nxt;
      expq.push_back(e);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) drive_bit(1'b0);
   endtask

   task automatic wr(bit sel, int ch, bit dat);
      drive_bit(1'b0, 1'b1, sel, ch, dat);
   endtask

   // Monitor: compares each bit in both clock phases.
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (expq.size() > 0) begin
            e = expq.pop_front();
            chk(e.tb, "blk_out", blk_out, e.blk);
            chk(e.tc, "chclk_out high phase", chclk_out, e.hi);
            #10;
            chk(e.tc, "chclk_out low phase", chclk_out, e.lo);
            chk(e.tb, "blk_out low phase", blk_out, e.blk);
         end
      end
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state, both clock phases
      repeat (3) @(posedge clk);
      #5;
      chk("R1", "blk_out in reset", blk_out, 1'b0);
      chk("R1", "chclk_out in reset", chclk_out, 1'b0);
      #10;
      chk("R1", "chclk_out in reset low", chclk_out, 1'b0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);

      // T1 pulse mode, masks loaded while streaming (R9, R3, R8)
      scen = "R9";
      drive_bit(1'b1);
      wr(0, 0, 1); wr(0, 3, 1); wr(0, 23, 1);
      wr(1, 1, 1); wr(1, 2, 1); wr(1, 10, 1); wr(1, 23, 1);
      scen = "R8";
      drive_bit(1'b1);
      run(192);
      // R2: free-running wrap without fsync
      scen = "R2";
      run(198);

      // T1 gapped, framing bit in then out (R6, R7)
      m_gap = 1'b1; m_fb = 1'b1;
      scen = "R7";
      drive_bit(1'b1);
      run(192);
      m_fb = 1'b0;
      drive_bit(1'b1);
      run(192);

      // R9: mask written just ahead of its channel
      scen = "R9";
      drive_bit(1'b1);
      run(38);
      wr(1, 5, 1);
      wr(0, 5, 1);
      run(150);

      // E1 gapped then pulse, upper channels (R4)
      m_e1 = 1'b1;
      scen = "R4";
      drive_bit(1'b1);
      run(255);
      wr(0, 27, 1); wr(1, 27, 1); wr(1, 31, 1); wr(0, 31, 1);
      m_gap = 1'b0;
      run(256);
      m_gap = 1'b1;
      run(256);

      // R10: only entries 24..31 set, T1 mode ignores them
      m_e1 = 1'b0;
      scen = "R10";
      for (int c = 0; c < 24; c++) begin
         wr(0, c, 0);
         wr(1, c, 0);
      end
      wr(0, 24, 1); wr(1, 24, 1);
      drive_bit(1'b1);
      run(192);
      m_gap = 1'b0;
      drive_bit(1'b1);
      run(192);

      // R2: fsync mid-frame realigns
      scen = "R2";
      wr(1, 2, 1); wr(0, 7, 1); wr(1, 7, 1);
      m_gap = 1'b1;
      run(50);
      drive_bit(1'b1);
      run(30);
      drive_bit(1'b1);
      run(200);

      // R11: mode toggled every few bits
      scen = "R11";
      drive_bit(1'b1);
      for (int i = 0; i < 40; i++) begin
         m_gap = ~m_gap;
         m_fb  = (i % 3) == 0;
         run(5);
      end

      // R2: switch from E1 to T1 beyond the T1 limit
      scen = "R2";
      m_e1 = 1'b1;
      drive_bit(1'b1);
      run(220);
      m_e1 = 1'b0;
      run(30);

      repeat (2) @(posedge clk);
      #20;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule